// File: doc/BRIEF.md
# Banked data memory address mapper

This unit sits between an 8-bit microcontroller core and its on-chip data RAMs. It joins a 768-byte expanded RAM and a 256-byte scratchpad RAM into a single 1 KB data space, and both arrays are part of the unit. Three request kinds arrive from the core, each with its own read strobe, write strobe and write data. The first is an indirect external-data access, addressed by an 8-bit register plus a 2-bit page select. The second is a data-pointer external-data access, addressed by a 16-bit pointer. The third is a direct-address access with an 8-bit address.

Direct accesses that fall in the 64-byte window from 0x40 to 0x7F can be redirected through a 4-bit bank number. This gives one 10-bit unified address. In that unified space the scratchpad occupies the lowest 256 bytes and the expanded RAM lies above it. External-data accesses go to the expanded RAM only when the on-chip enable is set and the address is inside the array. Any other external-data access raises a flag that hands the access to the off-chip memory interface. Read data comes back one clock after the request.

Top module: `xmem_mapper`

## Requirements
- R1: When `win_en` is 1 and `dir_addr` is in 0x40..0x7F, a direct access uses the unified address {`win_bank`, `dir_addr[5:0]`}. A unified address below 0x100 selects the scratchpad (`spad_cs`=1) at `spad_addr` equal to that unified address.
- R2: A unified address of 0x100 or more selects the expanded RAM (`xram_cs`=1) at `xram_addr` = unified address minus 0x100. For example, bank 8 with direct address 0x41 reaches expanded location 0x101.
- R3: When `win_en` is 0, or `dir_addr` is outside 0x40..0x7F, a direct access selects the scratchpad at `spad_addr` = `dir_addr`, with no change.
- R4: An indirect access with `ome`=1 and `page_sel` in 0..2 selects the expanded RAM at `xram_addr` = {`page_sel`, `ri_addr`}.
- R5: A data-pointer access with `ome`=1 and `dp_addr` below 768 selects the expanded RAM at `xram_addr` = `dp_addr[9:0]`.
- R6: An external-data access with `ome`=0, or with an address of 768 or more (this includes `page_sel`=3), raises `ext_sel` and drives neither `xram_cs` nor `spad_cs`. At most one of `xram_cs`, `spad_cs` and `ext_sel` is ever high.
- R7: A read returns its byte on `rdata` in the clock after the request. `rdata` is 0 in any cycle whose previous cycle held no on-chip read, and this includes the first cycle after reset.
- R8: When more than one request kind is active in a cycle, the direct access wins over the data-pointer access, and the data-pointer access wins over the indirect access. Only the winner's strobes and write data take effect.
- R9: With no strobe active, `xram_cs`, `spad_cs` and `ext_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_en | input | 1 | Window remap enable (bank register top bit) |
| win_bank | input | 4 | Window bank number |
| page_sel | input | 2 | Page select for indirect external accesses |
| ome | input | 1 | On-chip expanded RAM enable |
| ri_rd | input | 1 | Indirect access read strobe |
| ri_wr | input | 1 | Indirect access write strobe |
| ri_addr | input | 8 | Indirect register value |
| ri_wdata | input | 8 | Indirect write data |
| dp_rd | input | 1 | Data-pointer access read strobe |
| dp_wr | input | 1 | Data-pointer access write strobe |
| dp_addr | input | 16 | Data pointer |
| dp_wdata | input | 8 | Data-pointer write data |
| dir_rd | input | 1 | Direct access read strobe |
| dir_wr | input | 1 | Direct access write strobe |
| dir_addr | input | 8 | Direct address |
| dir_wdata | input | 8 | Direct write data |
| xram_cs | output | 1 | Expanded RAM selected this cycle |
| xram_addr | output | 10 | Expanded RAM address |
| spad_cs | output | 1 | Scratchpad selected this cycle |
| spad_addr | output | 8 | Scratchpad address |
| ext_sel | output | 1 | Access handed to the off-chip interface |
| rdata | output | 8 | Read data, one clock after the request |

## Verification
Address translation is combinational, so a wrong bank concatenation, offset or priority shows on `xram_addr`, `spad_addr` or the select lines in the same cycle as the request. Damage to the arrays shows later. A write that reaches the wrong array or the wrong location appears only when that location is read back, and a read can come many operations afterwards. For this reason every location is filled first through the window, and each later read is compared with a model of both arrays. A fault in the registered read source shows on `rdata` exactly one clock after the read.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int DW          = 8;
  localparam int XA_W        = 10;
  localparam int SA_W        = 8;
  localparam int DP_W        = 16;
  localparam int BANK_W      = 4;
  localparam int WIN_W       = 6;
  localparam int XRAM_DEPTH  = 768;
  localparam int SPAD_DEPTH  = 256;

  typedef enum logic [1:0] {REQ_IDLE, REQ_DIR, REQ_DPTR, REQ_RI} req_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_XRAM, SRC_SPAD} src_e;

  // the direct window spans the second 64-byte block of the direct space
  function automatic logic in_window(input logic [SA_W-1:0] a);
    return a[SA_W-1:WIN_W] == 2'b01;
  endfunction

  function automatic logic [XA_W-1:0] unified_addr(input logic [BANK_W-1:0] bank,
                                                    input logic [SA_W-1:0]   a);
    return {bank, a[WIN_W-1:0]};
  endfunction
endpackage

// File: rtl/xmem_arbiter.sv
module xmem_arbiter
  import xmem_pkg::*;
(
  input  logic dir_act,
  input  logic dp_act,
  input  logic ri_act,
  output req_e req
);
  always_comb begin
    if (dir_act)     req = REQ_DIR;
    else if (dp_act) req = REQ_DPTR;
    else if (ri_act) req = REQ_RI;
    else             req = REQ_IDLE;
  end
endmodule

// File: rtl/xmem_addr_map.sv
module xmem_addr_map
  import xmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  req_e              req,
  input  logic              win_en,
  input  logic [BANK_W-1:0] win_bank,
  input  logic [1:0]        page_sel,
  input  logic              ome,
  input  logic [SA_W-1:0]   ri_addr,
  input  logic [DP_W-1:0]   dp_addr,
  input  logic [SA_W-1:0]   dir_addr,
  output logic              xram_cs,
  output logic [XA_W-1:0]   xram_addr,
  output logic              spad_cs,
  output logic [SA_W-1:0]   spad_addr,
  output logic              ext_sel
);
  logic            win_hit;
  logic [XA_W-1:0] uni_addr;
  logic [DP_W-1:0] ext_addr;
  logic            ext_hit;

  assign win_hit  = win_en && in_window(dir_addr);
  assign uni_addr = win_hit ? unified_addr(win_bank, dir_addr)
                            : {{(XA_W-SA_W){1'b0}}, dir_addr};
  assign ext_addr = (req == REQ_RI) ? {{(DP_W-XA_W){1'b0}}, page_sel, ri_addr} : dp_addr;
  assign ext_hit  = ome && (ext_addr < DP_W'(XRAM_DEPTH));

  always_comb begin
    xram_cs   = 1'b0;
    xram_addr = '0;
    spad_cs   = 1'b0;
    spad_addr = '0;
    ext_sel   = 1'b0;
    case (req)
      REQ_DIR: begin
        if (uni_addr >= XA_W'(SPAD_DEPTH)) begin
          xram_cs   = 1'b1;
          xram_addr = uni_addr - XA_W'(SPAD_DEPTH);
        end else begin
          spad_cs   = 1'b1;
          spad_addr = uni_addr[SA_W-1:0];
        end
      end
      REQ_DPTR, REQ_RI: begin
        if (ext_hit) begin
          xram_cs   = 1'b1;
          xram_addr = ext_addr[XA_W-1:0];
        end else begin
          ext_sel   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xram_cs, spad_cs, ext_sel}));
  // R5
  xram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xram_cs |-> (xram_addr < XA_W'(XRAM_DEPTH)));
  // R2
  win_high_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == REQ_DIR && win_hit && win_bank >= 4'd4) |-> xram_cs);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == REQ_IDLE) |-> !(xram_cs || spad_cs || ext_sel));
endmodule

// File: rtl/xmem_sram.sv
module xmem_sram #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/xmem_mapper.sv
module xmem_mapper
  import xmem_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        win_en,
  input  logic [3:0]  win_bank,
  input  logic [1:0]  page_sel,
  input  logic        ome,
  input  logic        ri_rd,
  input  logic        ri_wr,
  input  logic [7:0]  ri_addr,
  input  logic [7:0]  ri_wdata,
  input  logic        dp_rd,
  input  logic        dp_wr,
  input  logic [15:0] dp_addr,
  input  logic [7:0]  dp_wdata,
  input  logic        dir_rd,
  input  logic        dir_wr,
  input  logic [7:0]  dir_addr,
  input  logic [7:0]  dir_wdata,
  output logic        xram_cs,
  output logic [9:0]  xram_addr,
  output logic        spad_cs,
  output logic [7:0]  spad_addr,
  output logic        ext_sel,
  output logic [7:0]  rdata
);
  req_e          req;
  logic          acc_rd, acc_wr;
  logic [DW-1:0] acc_wdata;
  logic [DW-1:0] xram_q, spad_q;
  src_e          src_q;
  logic          onchip_rd;

  xmem_arbiter u_arb (
    .dir_act (dir_rd | dir_wr),
    .dp_act  (dp_rd  | dp_wr),
    .ri_act  (ri_rd  | ri_wr),
    .req     (req)
  );

  always_comb begin
    case (req)
      REQ_DIR:  begin acc_rd = dir_rd; acc_wr = dir_wr; acc_wdata = dir_wdata; end
      REQ_DPTR: begin acc_rd = dp_rd;  acc_wr = dp_wr;  acc_wdata = dp_wdata;  end
      REQ_RI:   begin acc_rd = ri_rd;  acc_wr = ri_wr;  acc_wdata = ri_wdata;  end
      default:  begin acc_rd = 1'b0;   acc_wr = 1'b0;   acc_wdata = '0;        end
    endcase
  end

  xmem_addr_map u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .win_en    (win_en),
    .win_bank  (win_bank),
    .page_sel  (page_sel),
    .ome       (ome),
    .ri_addr   (ri_addr),
    .dp_addr   (dp_addr),
    .dir_addr  (dir_addr),
    .xram_cs   (xram_cs),
    .xram_addr (xram_addr),
    .spad_cs   (spad_cs),
    .spad_addr (spad_addr),
    .ext_sel   (ext_sel)
  );

  xmem_sram #(.DEPTH(XRAM_DEPTH), .DW(DW)) u_xram (
    .clk   (clk),
    .we    (xram_cs & acc_wr),
    .re    (xram_cs & acc_rd),
    .addr  (xram_addr),
    .wdata (acc_wdata),
    .q     (xram_q)
  );

  xmem_sram #(.DEPTH(SPAD_DEPTH), .DW(DW)) u_spad (
    .clk   (clk),
    .we    (spad_cs & acc_wr),
    .re    (spad_cs & acc_rd),
    .addr  (spad_addr),
    .wdata (acc_wdata),
    .q     (spad_q)
  );

  assign onchip_rd = acc_rd && (xram_cs || spad_cs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 src_q <= SRC_NONE;
    else if (acc_rd && xram_cs) src_q <= SRC_XRAM;
    else if (acc_rd && spad_cs) src_q <= SRC_SPAD;
    else                        src_q <= SRC_NONE;
  end

  always_comb begin
    case (src_q)
      SRC_XRAM: rdata = xram_q;
      SRC_SPAD: rdata = spad_q;
      default:  rdata = '0;
    endcase
  end

  // R7
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !onchip_rd |=> (rdata == '0));
  // R6
  ext_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |-> !(xram_cs && acc_wr));
endmodule

// File: tb/test_xmem_mapper.sv
module test_xmem_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        win_en;
  logic [3:0]  win_bank;
  logic [1:0]  page_sel;
  logic        ome;
  logic        ri_rd, ri_wr, dp_rd, dp_wr, dir_rd, dir_wr;
  logic [7:0]  ri_addr, ri_wdata, dp_wdata, dir_addr, dir_wdata;
  logic [15:0] dp_addr;
  logic        xram_cs, spad_cs, ext_sel;
  logic [9:0]  xram_addr;
  logic [7:0]  spad_addr, rdata;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] m_x [768];
  logic [7:0] m_s [256];

  bit       e_xcs, e_scs, e_ext, e_rd, e_wr;
  int       e_xa, e_sa;
  logic [7:0] e_wd;

  always #5 clk = ~clk;

  xmem_mapper i_xmem_mapper (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .win_bank(win_bank),
    .page_sel(page_sel), .ome(ome),
    .ri_rd(ri_rd), .ri_wr(ri_wr), .ri_addr(ri_addr), .ri_wdata(ri_wdata),
    .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_addr(dp_addr), .dp_wdata(dp_wdata),
    .dir_rd(dir_rd), .dir_wr(dir_wr), .dir_addr(dir_addr), .dir_wdata(dir_wdata),
    .xram_cs(xram_cs), .xram_addr(xram_addr), .spad_cs(spad_cs),
    .spad_addr(spad_addr), .ext_sel(ext_sel), .rdata(rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {ri_rd, ri_wr, dp_rd, dp_wr, dir_rd, dir_wr} = '0;
  endtask

  // expected routing, worked out as plain integer arithmetic
  task automatic predict();
    int u, ea;
    e_xcs = 0; e_scs = 0; e_ext = 0; e_xa = 0; e_sa = 0;
    e_rd = 0; e_wr = 0; e_wd = 8'h00;
    if (dir_rd || dir_wr) begin
      e_rd = dir_rd; e_wr = dir_wr; e_wd = dir_wdata;
      if (win_en && dir_addr >= 8'h40 && dir_addr < 8'h80)
        u = int'(win_bank) * 64 + (int'(dir_addr) - 64);
      else
        u = int'(dir_addr);
      if (u < 256) begin e_scs = 1; e_sa = u; end
      else         begin e_xcs = 1; e_xa = u - 256; end
    end else if (dp_rd || dp_wr || ri_rd || ri_wr) begin
      if (dp_rd || dp_wr) begin
        e_rd = dp_rd; e_wr = dp_wr; e_wd = dp_wdata; ea = int'(dp_addr);
      end else begin
        e_rd = ri_rd; e_wr = ri_wr; e_wd = ri_wdata;
        ea = int'(page_sel) * 256 + int'(ri_addr);
      end
      if (ome && ea < 768) begin e_xcs = 1; e_xa = ea; end
      else e_ext = 1;
    end
  endtask

  // drive at a negedge, check routing, then check read data a clock later
  task automatic run_op(input string tag);
    int exp_rd;
    predict();
    #1;
    chk({tag, " xram_cs"}, int'(xram_cs), int'(e_xcs));
    chk({tag, " spad_cs"}, int'(spad_cs), int'(e_scs));
    chk({tag, " ext_sel"}, int'(ext_sel), int'(e_ext));
    if (e_xcs) chk({tag, " xram_addr"}, int'(xram_addr), e_xa);
    if (e_scs) chk({tag, " spad_addr"}, int'(spad_addr), e_sa);
    exp_rd = 0;
    if (e_rd && e_xcs) exp_rd = int'(m_x[e_xa]);
    if (e_rd && e_scs) exp_rd = int'(m_s[e_sa]);
    if (e_wr && e_xcs) m_x[e_xa] = e_wd;
    if (e_wr && e_scs) m_s[e_sa] = e_wd;
    @(negedge clk);
    chk({tag, " rdata R7"}, int'(rdata), exp_rd);
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; win_en = 0; win_bank = 0; page_sel = 0; ome = 1;
    ri_addr = 0; ri_wdata = 0; dp_addr = 0; dp_wdata = 0;
    dir_addr = 0; dir_wdata = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state, R9 idle selects
    chk("R7 reset rdata", int'(rdata), 0);
    chk("R9 idle selects", int'({xram_cs, spad_cs, ext_sel}), 0);

    // R1 R2 fill every location through the window
    win_en = 1;
    for (int b = 0; b < 16; b++)
      for (int a = 0; a < 64; a++) begin
        win_bank = 4'(b); dir_addr = 8'(8'h40 + a);
        dir_wdata = 8'($urandom); dir_wr = 1;
        run_op(b < 4 ? "R1 fill" : "R2 fill");
      end

    // R2 example: bank reg 0x88 -> bank 8, write 0x30 at 0x41 lands at 0x101
    win_en = 1; win_bank = 4'd8; dir_addr = 8'h41; dir_wdata = 8'h30; dir_wr = 1;
    run_op("R2 example write");
    ome = 1; dp_addr = 16'h0101; dp_rd = 1;
    run_op("R5 example readback");
    chk("R2 example value", int'(m_x[257]), 8'h30);

    // R3 window disabled and outside window
    win_en = 0; win_bank = 4'd8; dir_addr = 8'h41; dir_rd = 1;
    run_op("R3 window off");
    win_en = 1; win_bank = 4'd15; dir_addr = 8'h80; dir_rd = 1;
    run_op("R3 outside window");

    // R4 R6 page select boundaries
    page_sel = 2'd2; ri_addr = 8'hFF; ri_rd = 1;
    run_op("R4 top page");
    page_sel = 2'd3; ri_addr = 8'h00; ri_wr = 1; ri_wdata = 8'hA5;
    run_op("R6 page three");

    // R5 R6 data pointer boundaries and enable
    dp_addr = 16'h02FF; dp_rd = 1;
    run_op("R5 last byte");
    dp_addr = 16'h0300; dp_rd = 1;
    run_op("R6 past end");
    dp_addr = 16'h8010; dp_rd = 1;
    run_op("R6 high pointer");
    ome = 0; dp_addr = 16'h0010; dp_wr = 1; dp_wdata = 8'h5A;
    run_op("R6 ome off write");
    ome = 1; dp_addr = 16'h0010; dp_rd = 1;
    run_op("R6 ome off untouched");

    // R8 priority
    win_en = 0; dir_addr = 8'h22; dir_rd = 1;
    dp_addr = 16'h0044; dp_wr = 1; dp_wdata = 8'h11;
    ri_addr = 8'h33; page_sel = 0; ri_wr = 1; ri_wdata = 8'h22;
    run_op("R8 direct wins");
    dp_addr = 16'h0044; dp_rd = 1;
    run_op("R8 dp not written");
    dp_addr = 16'h0050; dp_wr = 1; dp_wdata = 8'h77;
    ri_addr = 8'h50; page_sel = 2'd1; ri_wr = 1; ri_wdata = 8'h66;
    run_op("R8 dptr wins");
    page_sel = 2'd1; ri_addr = 8'h50; ri_rd = 1;
    run_op("R8 ri not written");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int kind, multi;
      win_en = 1'($urandom); win_bank = 4'($urandom);
      page_sel = 2'($urandom); ome = ($urandom % 8) != 0;
      dir_addr = 8'($urandom); ri_addr = 8'($urandom);
      dp_addr = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 800);
      dir_wdata = 8'($urandom); dp_wdata = 8'($urandom); ri_wdata = 8'($urandom);
      kind = $urandom % 4;
      multi = ($urandom % 6) == 0;
      if (kind == 1 || multi) begin if ($urandom % 2) dir_rd = 1; else dir_wr = 1; end
      if (kind == 2 || multi) begin if ($urandom % 2) dp_rd = 1;  else dp_wr = 1;  end
      if (kind == 3 || multi) begin if ($urandom % 2) ri_rd = 1;  else ri_wr = 1;  end
      run_op(kind == 0 && !multi ? "R9 random idle" : "R8 random mix");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule